// File: doc/BRIEF.md
# Saturating Priority History Stack

This block keeps a short history of interrupt priority levels. When an interrupt is accepted, the current priority is pushed. When the handler signals end of interrupt, the stack is popped, and the preempted priority reappears on the output. The stack holds a fixed number of 4-bit entries. It never stalls and it never reports an error. A push onto a full stack discards the oldest entry. A pop from an empty stack yields priority 0. In an interrupt controller a lost level-0 entry does not matter, because an empty stack reads as 0 and so regenerates it.

The block has no register access. Only the push and pop strobes change it. The output always shows the top entry, and it is formed combinationally. As a result, the value being removed is on the output during the same cycle the pop is sampled.

An occupancy controller tracks the fill level with a counter and a three-state machine:

- `OCC_EMPTY` means no entries are held.
- `OCC_PARTIAL` means between 1 and 13 entries are held.
- `OCC_FULL` means 14 entries are held.

The named transitions are:

- *first-fill*: `OCC_EMPTY`→`OCC_PARTIAL`, on a push or on a push with a simultaneous pop.
- *fill-up*: `OCC_PARTIAL`→`OCC_FULL`, on a push at 13 entries.
- *drain-out*: `OCC_PARTIAL`→`OCC_EMPTY`, on a pop at 1 entry.
- *unfill*: `OCC_FULL`→`OCC_PARTIAL`, on a pop.

Every other operation keeps the state. This includes a push while full, a pop while empty, and any simultaneous push and pop outside `OCC_EMPTY`. A storage unit built as a shift array holds the entries, with slot 0 on top.

Top module: `prio_hist_stack`

## Requirements
- R1: A synchronous active-high `rst` empties the stack. In the cycle after reset is sampled, `top_prio_o` is 0, and a following pop leaves it at 0.
- R2: When `push_i` is sampled high, `top_prio_o` shows the value of `push_prio_i` (a 4-bit priority, 0 to 15) from the next cycle on.
- R3: Pops return entries in reverse push order. After each pop, the next older entry is on `top_prio_o` in the following cycle, or 0 once the stack is empty.
- R4: The stack holds 14 entries. A 15th push without an intervening pop drops the earliest-pushed entry and keeps the newest. Pushing 1 to 15 and then popping 14 times shows 15, 14, …, 2 on the output, and after the 14th pop it shows 0.
- R5: A pop on an empty stack leaves `top_prio_o` at 0 and the stack empty. A later single push followed by a pop returns the output to 0.
- R6: When `push_i` and `pop_i` are both high in one cycle, the pop is applied first and then the push. The top entry is replaced by the pushed value, older entries are unchanged, and the occupancy is unchanged. The one exception is an empty stack, which ends up holding exactly one entry.
- R7: During the cycle in which a pop is sampled, `top_prio_o` already carries the value that the pop removes.
- R8: A cycle with neither strobe high leaves `top_prio_o` and the stored contents unchanged.
- R9: A pushed value of 0 occupies an entry like any other value. For example, push 7, push 0, pop gives 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset, empties the stack |
| push_i | input | 1 | Save `push_prio_i` on top (interrupt accepted) |
| pop_i | input | 1 | Remove the top entry (end of interrupt) |
| push_prio_i | input | PRIO_W (4) | Priority value to save |
| top_prio_o | output | PRIO_W (4) | Current top entry, 0 when empty |

## Verification
The push and pop strobes can arrive in the same cycle. In that case the block must act as a pop followed by a push.

The bench provokes this case three ways:

- on a partly filled stack, where the next pop must reveal the untouched older entry;
- on an empty stack, where exactly one entry must result and one pop must bring back 0;
- on a full stack, where the occupancy must stay at 14, so that 14 pops return the replaced top, then the 13 older entries in order, and then 0.

In each case the verdict is read only from `top_prio_o`, both before and after the clock edges that follow.

// File: rtl/prio_hist_pkg.sv
package prio_hist_pkg;

    typedef enum logic [1:0] {
        OCC_EMPTY,
        OCC_PARTIAL,
        OCC_FULL
    } occ_state_e;

    typedef enum logic [1:0] {
        OP_IDLE,
        OP_PUSH,
        OP_POP,
        OP_SWAP
    } stack_op_e;

    function automatic stack_op_e decode_op(input logic push, input logic pop);
        if (push && pop) return OP_SWAP;
        if (push)        return OP_PUSH;
        if (pop)         return OP_POP;
        return OP_IDLE;
    endfunction

endpackage

// File: rtl/prio_hist_ctrl.sv
module prio_hist_ctrl
    import prio_hist_pkg::*;
#(
    parameter int DEPTH = 14
) (
    input  logic      clk,
    input  logic      rst,
    input  stack_op_e op,
    output logic      is_empty_o
);

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    occ_state_e       state_q, state_nxt;
    logic [CNT_W-1:0] cnt_q, cnt_nxt;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= OCC_EMPTY;
            cnt_q   <= '0;
        end else begin
            state_q <= state_nxt;
            cnt_q   <= cnt_nxt;
        end
    end

    // transitions: pop is applied before push on OP_SWAP
    always_comb begin
        state_nxt = state_q;
        cnt_nxt   = cnt_q;
        unique case (state_q)
            OCC_EMPTY: begin
                if (op == OP_PUSH || op == OP_SWAP) begin
                    cnt_nxt   = CNT_ONE;
                    state_nxt = (DEPTH == 1) ? OCC_FULL : OCC_PARTIAL;
                end
            end
            OCC_PARTIAL: begin
                if (op == OP_PUSH) begin
                    cnt_nxt = cnt_q + CNT_ONE;
                    if (cnt_q == CNT_LAST) state_nxt = OCC_FULL;
                end else if (op == OP_POP) begin
                    cnt_nxt = cnt_q - CNT_ONE;
                    if (cnt_q == CNT_ONE) state_nxt = OCC_EMPTY;
                end
            end
            OCC_FULL: begin
                if (op == OP_POP) begin
                    cnt_nxt   = CNT_LAST;
                    state_nxt = (DEPTH == 1) ? OCC_EMPTY : OCC_PARTIAL;
                end
            end
            default: begin
                state_nxt = OCC_EMPTY;
                cnt_nxt   = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        is_empty_o = (state_q == OCC_EMPTY);
    end

    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (rst)
        (cnt_q <= CNT_MAX));

    p_full_match_r4: assert property (@(posedge clk) disable iff (rst)
        ((state_q == OCC_FULL) == (cnt_q == CNT_MAX)));

    p_full_push_r4: assert property (@(posedge clk) disable iff (rst)
        (state_q == OCC_FULL && op == OP_PUSH) |=> (state_q == OCC_FULL));

    p_pop_empty_r5: assert property (@(posedge clk) disable iff (rst)
        (state_q == OCC_EMPTY && op == OP_POP) |=> (state_q == OCC_EMPTY));

    p_swap_count_r6: assert property (@(posedge clk) disable iff (rst)
        (op == OP_SWAP && state_q != OCC_EMPTY) |=> $stable(cnt_q));

    p_swap_empty_r6: assert property (@(posedge clk) disable iff (rst)
        (op == OP_SWAP && state_q == OCC_EMPTY) |=> (cnt_q == CNT_ONE));

endmodule

// File: rtl/prio_hist_store.sv
module prio_hist_store
    import prio_hist_pkg::*;
#(
    parameter int PRIO_W = 4,
    parameter int DEPTH  = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  stack_op_e         op,
    input  logic [PRIO_W-1:0] push_prio_i,
    output logic [PRIO_W-1:0] top_o
);

    logic [PRIO_W-1:0] slot_q   [DEPTH];
    logic [PRIO_W-1:0] newer_w  [DEPTH];
    logic [PRIO_W-1:0] older_w  [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        if (i == 0) begin : g_head
            assign newer_w[i] = push_prio_i;
        end else begin : g_body
            assign newer_w[i] = slot_q[i-1];
        end

        if (i == DEPTH - 1) begin : g_tail
            assign older_w[i] = '0;
        end else begin : g_inner
            assign older_w[i] = slot_q[i+1];
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                slot_q[i] <= '0;
            end else begin
                unique case (op)
                    OP_PUSH: slot_q[i] <= newer_w[i];
                    OP_POP:  slot_q[i] <= older_w[i];
                    OP_SWAP: if (i == 0) slot_q[i] <= push_prio_i;
                    OP_IDLE: ;
                    default: ;
                endcase
            end
        end
    end

    assign top_o = slot_q[0];

    if (DEPTH > 1) begin : g_chk
        p_swap_keeps_r6: assert property (@(posedge clk) disable iff (rst)
            (op == OP_SWAP) |=> (slot_q[1] == $past(slot_q[1])));
    end

    p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (op == OP_IDLE) |=> $stable(top_o));

endmodule

// File: rtl/prio_hist_stack.sv
module prio_hist_stack
    import prio_hist_pkg::*;
#(
    parameter int PRIO_W = 4,
    parameter int DEPTH  = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push_i,
    input  logic              pop_i,
    input  logic [PRIO_W-1:0] push_prio_i,
    output logic [PRIO_W-1:0] top_prio_o
);

    stack_op_e         op;
    logic              is_empty;
    logic [PRIO_W-1:0] store_top;

    assign op = decode_op(push_i, pop_i);

    prio_hist_ctrl #(
        .DEPTH (DEPTH)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .op         (op),
        .is_empty_o (is_empty)
    );

    prio_hist_store #(
        .PRIO_W (PRIO_W),
        .DEPTH  (DEPTH)
    ) u_store (
        .clk         (clk),
        .rst         (rst),
        .op          (op),
        .push_prio_i (push_prio_i),
        .top_o       (store_top)
    );

    assign top_prio_o = is_empty ? '0 : store_top;

    p_push_top_r2: assert property (@(posedge clk) disable iff (rst)
        push_i |=> (top_prio_o == $past(push_prio_i)));

    p_empty_zero_r5: assert property (@(posedge clk) disable iff (rst)
        is_empty |-> (store_top == '0));

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (rst || top_prio_o == '0));

endmodule

// File: tb/prio_hist_stack_bench.sv
module prio_hist_stack_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 20000;
    localparam int N_VEC      = 15;

    // row: {push, pop, prio[3:0], expected top after edge[3:0], requirement[3:0]}
    localparam logic [13:0] VEC [N_VEC] = '{
        {1'b1, 1'b0, 4'd5,  4'd5,  4'd2},
        {1'b1, 1'b0, 4'd9,  4'd9,  4'd2},
        {1'b0, 1'b0, 4'd3,  4'd9,  4'd8},
        {1'b0, 1'b1, 4'd0,  4'd5,  4'd3},
        {1'b1, 1'b0, 4'd3,  4'd3,  4'd2},
        {1'b1, 1'b1, 4'd12, 4'd12, 4'd6},
        {1'b0, 1'b1, 4'd0,  4'd5,  4'd6},
        {1'b0, 1'b1, 4'd0,  4'd0,  4'd3},
        {1'b0, 1'b1, 4'd0,  4'd0,  4'd5},
        {1'b1, 1'b1, 4'd6,  4'd6,  4'd6},
        {1'b0, 1'b1, 4'd0,  4'd0,  4'd6},
        {1'b1, 1'b0, 4'd7,  4'd7,  4'd2},
        {1'b1, 1'b0, 4'd0,  4'd0,  4'd9},
        {1'b0, 1'b1, 4'd0,  4'd7,  4'd9},
        {1'b0, 1'b1, 4'd0,  4'd0,  4'd9}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       push = 1'b0;
    logic       pop = 1'b0;
    logic [3:0] prio = 4'd0;
    logic [3:0] top;
    int         n_tests = 0;
    int         n_fail = 0;
    logic       done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    prio_hist_stack u_prio_hist_stack (
        .clk         (clk),
        .rst         (rst),
        .push_i      (push),
        .pop_i       (pop),
        .push_prio_i (prio),
        .top_prio_o  (top)
    );

    function automatic string tag_of(input logic [3:0] n);
        case (n)
            4'd2:    return "R2";
            4'd3:    return "R3";
            4'd5:    return "R5";
            4'd6:    return "R6";
            4'd8:    return "R8";
            4'd9:    return "R9";
            default: return "R?";
        endcase
    endfunction

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: top_prio_o=%0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic drive(input logic pu, input logic po, input logic [3:0] pr);
        @(negedge clk);
        push = pu;
        pop  = po;
        prio = pr;
        #1;
    endtask

    task automatic commit();
        @(posedge clk);
        #1;
        push = 1'b0;
        pop  = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        check("R1 reset", top, 4'd0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete, cycles=%0d expected fewer", WD_CYCLES);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset state", top, 4'd0);
        @(negedge clk);
        rst = 1'b0;

        // table walk
        for (int i = 0; i < N_VEC; i++) begin
            drive(VEC[i][13], VEC[i][12], VEC[i][11:8]);
            commit();
            check(tag_of(VEC[i][3:0]), top, VEC[i][7:4]);
        end

        // R1: reset mid-run empties the stack
        for (int k = 1; k <= 3; k++) begin
            drive(1'b1, 1'b0, 4'(k + 10));
            commit();
        end
        do_reset();
        drive(1'b0, 1'b1, 4'd0);
        commit();
        check("R1 pop after reset", top, 4'd0);

        // R4 / R7: overflow drops earliest entry
        for (int k = 1; k <= 15; k++) begin
            drive(1'b1, 1'b0, 4'(k));
            commit();
        end
        check("R4 top after 15 pushes", top, 4'd15);
        for (int k = 15; k >= 2; k--) begin
            drive(1'b0, 1'b1, 4'd0);
            check("R7 value on output while pop sampled", top, 4'(k));
            commit();
        end
        check("R4 oldest entry dropped", top, 4'd0);
        drive(1'b0, 1'b1, 4'd0);
        commit();
        check("R5 pop on empty", top, 4'd0);

        // R6: swap on full stack keeps 14 entries
        for (int k = 1; k <= 14; k++) begin
            drive(1'b1, 1'b0, 4'(k));
            commit();
        end
        drive(1'b1, 1'b1, 4'd9);
        check("R7 pre-swap top", top, 4'd14);
        commit();
        check("R6 swap on full top", top, 4'd9);
        drive(1'b0, 1'b1, 4'd0);
        commit();
        check("R6 swap on full keeps older", top, 4'd13);
        for (int k = 12; k >= 1; k--) begin
            drive(1'b0, 1'b1, 4'd0);
            commit();
        end
        check("R6 last entry after full swap", top, 4'd1);
        drive(1'b0, 1'b1, 4'd0);
        commit();
        check("R6 occupancy unchanged by swap", top, 4'd0);

        // R8: idle cycles with push_prio_i changing
        drive(1'b1, 1'b0, 4'd4);
        commit();
        for (int k = 0; k < 4; k++) begin
            drive(1'b0, 1'b0, 4'(k + 11));
            commit();
        end
        check("R8 idle hold", top, 4'd4);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule